// File: doc/BRIEF.md
# Bus Event Performance Counter

This block is a single saturating event counter for a bridge that sits between a packet link and a parallel PCI-style bus. A control register holds three things: a global count enable, a mode bit, and a five-bit event-enable field. The mode bit decides what each of the five enables means.

In transaction mode, four enables pick command types: read responses, nonposted writes, posted writes, and operations headed for the bus. The fifth enable chooses what is counted for the selected types. It either adds one per command or adds the number of data words each command carries. In bus-timing mode, the same five enables select other events: discarded prefetch data, chained posts, inbound read latency clocks, wait-state clocks and idle bus clocks. Discards and chained posts add a multi-unit amount in one clock.

The events arrive as per-cycle strobes with small count values, together with the bus handshake lines. Software reads back the control register and the counter value. It can also write the counter to preset it or clear it.

Top module: `bus_evt_perf_counter`

## Requirements
- R1: After reset, the control readback and the counter value are both zero.
- R2: A write with `reg_wr_sel`=0 loads the control register. Bit 0 is the global enable, bit 1 is the mode (0 = transaction, 1 = bus-timing), and bits 12:8 are the event enables. Every other readback bit is zero.
- R3: While bit 0 of the control register is 0, no event changes the counter.
- R4: In transaction mode with bit 9 clear, each strobed command adds one when its type is enabled. The type enables are bit 12 for read responses, bit 11 for nonposted writes, bit 10 for posted writes and bit 8 for bus-destined operations. The counter adds the total over all enabled types.
- R5: In transaction mode with bit 9 set, each strobed and enabled command adds its data-word count instead of one.
- R6: In bus-timing mode with bit 12 set, a clock with a discard strobe adds the discard amount (0 to 15).
- R7: In bus-timing mode with bit 11 set, a chained-post first-data strobe adds the chained packet count (2, 3 or 4).
- R8: In bus-timing mode with bit 8 set, each clock in which frame, irdy and trdy are all low adds one.
- R9: In bus-timing mode, bit 10 adds one per inbound-read-latency clock and bit 9 adds one per wait-state clock.
- R10: Increments from several enabled events in the same clock are summed into a single update of the counter.
- R11: The counter saturates at all ones and never wraps.
- R12: A write with `reg_wr_sel`=1 loads the counter with the written value. This write wins over any increment in the same clock.
- R13: Strobes whose enable is clear, and strobes that belong to the mode not currently selected, leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 control, 1 counter |
| reg_wr_data | input | CNT_W | Write data |
| cmd_rd_rsp | input | 1 | Read response command this clock |
| cmd_np_wr | input | 1 | Nonposted write or read-modify-write command |
| cmd_p_wr | input | 1 | Posted write command |
| cmd_to_bus | input | 1 | Operation whose destination is the bus |
| words_rd_rsp | input | WORD_W | Data words of the read response |
| words_np_wr | input | WORD_W | Data words of the nonposted write |
| words_p_wr | input | WORD_W | Data words of the posted write |
| words_to_bus | input | WORD_W | Data words of the bus-destined operation |
| disc_vld | input | 1 | Prefetched data discarded this clock |
| disc_amt | input | DISC_W | Amount of discarded data |
| chain_first | input | 1 | Chained post moves its first data |
| chain_pkts | input | PKT_W | Number of packets in the chain |
| rd_lat_cyc | input | 1 | Clock of inbound read latency |
| wait_cyc | input | 1 | Wait-state bus clock |
| bus_frame | input | 1 | FRAME asserted (active high) |
| bus_irdy | input | 1 | IRDY asserted (active high) |
| bus_trdy | input | 1 | TRDY asserted (active high) |
| ctl_rd_data | output | CNT_W | Control register readback |
| cnt_value | output | CNT_W | Counter value |

## Verification
Each event feeds the counter through exactly one register, so a bad enable decode, a wrong mode select or a bad summing term shows up as a wrong counter value one clock after the strobe. Because the bench clears the counter before each scenario, it can tell which step went wrong. A saturation or write-priority fault corrupts the value on the same edge, and that wrong value stays in the counter until the next write. A control register fault shows directly in the readback on the clock after the write.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;

    localparam int CTL_GEN_BIT  = 0;
    localparam int CTL_MODE_BIT = 1;
    localparam int CTL_EN_LSB   = 8;
    localparam int CTL_EN_W     = 5;

    typedef enum logic {
        MODE_TXN = 1'b0,
        MODE_BUS = 1'b1
    } cnt_mode_e;

    // Packed MSB first: first field lands on control bit 12.
    typedef struct packed {
        logic rdrsp_or_disc;   // bit 12
        logic npwr_or_chain;   // bit 11
        logic pwr_or_lat;      // bit 10
        logic words_or_wait;   // bit 9
        logic tobus_or_idle;   // bit 8
    } evt_en_t;

    typedef struct packed {
        evt_en_t   en;
        cnt_mode_e mode;
        logic      gen;
    } ctl_t;

endpackage

// File: rtl/txn_incr.sv
module txn_incr #(
    parameter int NTYPES = 4,
    parameter int WORD_W = 4,
    parameter int INC_W  = 8
) (
    input  logic [NTYPES-1:0]        strb,
    input  logic [NTYPES*WORD_W-1:0] words,
    input  logic [NTYPES-1:0]        type_en,
    input  logic                     count_words,
    output logic [INC_W-1:0]         inc
);

    logic [INC_W-1:0] term [NTYPES];

    for (genvar g = 0; g < NTYPES; g++) begin : g_term
        always_comb begin
            if (strb[g] && type_en[g]) begin
                term[g] = count_words ? INC_W'(words[g*WORD_W +: WORD_W])
                                      : INC_W'(1);
            end else begin
                term[g] = '0;
            end
        end
    end

    always_comb begin
        inc = '0;
        for (int i = 0; i < NTYPES; i++) begin
            inc = inc + term[i];
        end
    end

endmodule

// File: rtl/bus_incr.sv
module bus_incr
    import perf_cnt_pkg::*;
#(
    parameter int DISC_W = 4,
    parameter int PKT_W  = 3,
    parameter int INC_W  = 8
) (
    input  evt_en_t           en,
    input  logic              disc_vld,
    input  logic [DISC_W-1:0] disc_amt,
    input  logic              chain_first,
    input  logic [PKT_W-1:0]  chain_pkts,
    input  logic              rd_lat_cyc,
    input  logic              wait_cyc,
    input  logic              bus_frame,
    input  logic              bus_irdy,
    input  logic              bus_trdy,
    output logic [INC_W-1:0]  inc
);

    logic idle;
    logic [INC_W-1:0] t_disc, t_chain, t_lat, t_wait, t_idle;

    always_comb begin
        idle    = !(bus_frame || bus_irdy || bus_trdy);
        t_disc  = (en.rdrsp_or_disc && disc_vld)    ? INC_W'(disc_amt)   : '0;
        t_chain = (en.npwr_or_chain && chain_first) ? INC_W'(chain_pkts) : '0;
        t_lat   = INC_W'(en.pwr_or_lat && rd_lat_cyc);
        t_wait  = INC_W'(en.words_or_wait && wait_cyc);
        t_idle  = INC_W'(en.tobus_or_idle && idle);
        inc     = t_disc + t_chain + t_lat + t_wait + t_idle;
    end

endmodule

// File: rtl/bus_evt_perf_counter.sv
module bus_evt_perf_counter
    import perf_cnt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WORD_W = 4,
    parameter int DISC_W = 4,
    parameter int PKT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [CNT_W-1:0]  reg_wr_data,
    input  logic              cmd_rd_rsp,
    input  logic              cmd_np_wr,
    input  logic              cmd_p_wr,
    input  logic              cmd_to_bus,
    input  logic [WORD_W-1:0] words_rd_rsp,
    input  logic [WORD_W-1:0] words_np_wr,
    input  logic [WORD_W-1:0] words_p_wr,
    input  logic [WORD_W-1:0] words_to_bus,
    input  logic              disc_vld,
    input  logic [DISC_W-1:0] disc_amt,
    input  logic              chain_first,
    input  logic [PKT_W-1:0]  chain_pkts,
    input  logic              rd_lat_cyc,
    input  logic              wait_cyc,
    input  logic              bus_frame,
    input  logic              bus_irdy,
    input  logic              bus_trdy,
    output logic [CNT_W-1:0]  ctl_rd_data,
    output logic [CNT_W-1:0]  cnt_value
);

    localparam int NTYPES = 4;
    localparam int INC_W  = 8;

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    logic [INC_W-1:0] txn_inc, bus_inc, sel_inc;
    logic [CNT_W:0]   sum_wide;

    // Type index: 0 read response, 1 nonposted write, 2 posted write, 3 to bus
    txn_incr #(
        .NTYPES (NTYPES),
        .WORD_W (WORD_W),
        .INC_W  (INC_W)
    ) u_txn (
        .strb        ({cmd_to_bus, cmd_p_wr, cmd_np_wr, cmd_rd_rsp}),
        .words       ({words_to_bus, words_p_wr, words_np_wr, words_rd_rsp}),
        .type_en     ({state_q.ctl.en.tobus_or_idle, state_q.ctl.en.pwr_or_lat,
                       state_q.ctl.en.npwr_or_chain, state_q.ctl.en.rdrsp_or_disc}),
        .count_words (state_q.ctl.en.words_or_wait),
        .inc         (txn_inc)
    );

    bus_incr #(
        .DISC_W (DISC_W),
        .PKT_W  (PKT_W),
        .INC_W  (INC_W)
    ) u_bus (
        .en          (state_q.ctl.en),
        .disc_vld    (disc_vld),
        .disc_amt    (disc_amt),
        .chain_first (chain_first),
        .chain_pkts  (chain_pkts),
        .rd_lat_cyc  (rd_lat_cyc),
        .wait_cyc    (wait_cyc),
        .bus_frame   (bus_frame),
        .bus_irdy    (bus_irdy),
        .bus_trdy    (bus_trdy),
        .inc         (bus_inc)
    );

    always_comb begin
        state_d = state_q;

        if (!state_q.ctl.gen) begin
            sel_inc = '0;
        end else if (state_q.ctl.mode == MODE_BUS) begin
            sel_inc = bus_inc;
        end else begin
            sel_inc = txn_inc;
        end

        sum_wide = {1'b0, state_q.cnt} + (CNT_W+1)'(sel_inc);
        state_d.cnt = sum_wide[CNT_W] ? '1 : sum_wide[CNT_W-1:0];

        if (reg_wr_en) begin
            if (reg_wr_sel) begin
                state_d.cnt = reg_wr_data;
            end else begin
                state_d.ctl.gen  = reg_wr_data[CTL_GEN_BIT];
                state_d.ctl.mode = cnt_mode_e'(reg_wr_data[CTL_MODE_BIT]);
                state_d.ctl.en   = evt_en_t'(reg_wr_data[CTL_EN_LSB +: CTL_EN_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctl_rd_data = CNT_W'({state_q.ctl.en, 6'b0, state_q.ctl.mode, state_q.ctl.gen});
    assign cnt_value   = state_q.cnt;

endmodule

// File: rtl/perf_cnt_chk.sv
module perf_cnt_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             reg_wr_sel,
    input logic [CNT_W-1:0] reg_wr_data,
    input logic [CNT_W-1:0] ctl_rd_data,
    input logic [CNT_W-1:0] cnt_value
);

    localparam logic [CNT_W-1:0] CTL_MASK = CNT_W'(32'h0000_1F03);

    logic cnt_wr;
    assign cnt_wr = reg_wr_en && reg_wr_sel;

    p_ctl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_data & ~CTL_MASK) == '0);

    p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rd_data[0] && !cnt_wr) |=> $stable(cnt_value));

    p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> cnt_value >= $past(cnt_value));

    p_sat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_value == '1 && !cnt_wr) |=> cnt_value == '1);

    p_wr_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_value == $past(reg_wr_data));

endmodule

bind bus_evt_perf_counter perf_cnt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .ctl_rd_data (ctl_rd_data),
    .cnt_value   (cnt_value)
);

// File: tb/test_bus_evt_perf_counter.sv
`timescale 1ns/1ps
module test_bus_evt_perf_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        cmd_rd_rsp = 0, cmd_np_wr = 0, cmd_p_wr = 0, cmd_to_bus = 0;
    logic [3:0]  words_rd_rsp = 0, words_np_wr = 0, words_p_wr = 0, words_to_bus = 0;
    logic        disc_vld = 0;
    logic [3:0]  disc_amt = 0;
    logic        chain_first = 0;
    logic [2:0]  chain_pkts = 0;
    logic        rd_lat_cyc = 0, wait_cyc = 0;
    logic        bus_frame = 0, bus_irdy = 0, bus_trdy = 0;
    logic [31:0] ctl_rd_data, cnt_value;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bus_evt_perf_counter i_bus_evt_perf_counter (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_rd_rsp = 0; cmd_np_wr = 0; cmd_p_wr = 0; cmd_to_bus = 0;
        words_rd_rsp = 0; words_np_wr = 0; words_p_wr = 0; words_to_bus = 0;
        disc_vld = 0; disc_amt = 0; chain_first = 0; chain_pkts = 0;
        rd_lat_cyc = 0; wait_cyc = 0;
        bus_frame = 1; bus_irdy = 0; bus_trdy = 0;
        reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr_ctl(logic [31:0] v);
        reg_wr_en = 1; reg_wr_sel = 0; reg_wr_data = v;
        step();
    endtask

    task automatic wr_cnt(logic [31:0] v);
        reg_wr_en = 1; reg_wr_sel = 1; reg_wr_data = v;
        step();
    endtask

    task automatic t_reset();
        chk("R1 ctl", ctl_rd_data, 32'h0);
        chk("R1 cnt", cnt_value, 32'h0);
    endtask

    task automatic t_ctl();
        wr_ctl(32'hFFFF_FFFF);
        chk("R2 readback", ctl_rd_data, 32'h0000_1F03);
        wr_ctl(32'h0);
        chk("R2 clear", ctl_rd_data, 32'h0);
    endtask

    task automatic t_gate();
        wr_ctl(32'h0000_1D00);
        wr_cnt(32'h0);
        cmd_rd_rsp = 1; cmd_np_wr = 1; cmd_p_wr = 1; cmd_to_bus = 1;
        step();
        chk("R3 gated", cnt_value, 32'h0);
    endtask

    task automatic t_txn_cmd();
        wr_ctl(32'h0000_1D01);
        wr_cnt(32'h0);
        cmd_rd_rsp = 1; cmd_p_wr = 1;
        step();
        chk("R4 rd+pw", cnt_value, 32'd2);
        cmd_np_wr = 1; cmd_to_bus = 1; words_np_wr = 7; words_to_bus = 7;
        step();
        chk("R4 np+bus ignore words", cnt_value, 32'd4);
        disc_vld = 1; disc_amt = 9; wait_cyc = 1; rd_lat_cyc = 1;
        step();
        chk("R13 bus events in txn mode", cnt_value, 32'd4);
        wr_ctl(32'h0000_1001);
        cmd_rd_rsp = 1; cmd_np_wr = 1; cmd_p_wr = 1; cmd_to_bus = 1;
        step();
        chk("R13 only rd enabled", cnt_value, 32'd5);
    endtask

    task automatic t_words();
        wr_ctl(32'h0000_1F01);
        wr_cnt(32'h0);
        cmd_rd_rsp = 1; cmd_np_wr = 1; cmd_p_wr = 1; cmd_to_bus = 1;
        words_rd_rsp = 5; words_np_wr = 3; words_p_wr = 15; words_to_bus = 2;
        step();
        chk("R5 R10 word sum", cnt_value, 32'd25);
        wr_ctl(32'h0000_1201);
        cmd_rd_rsp = 1; cmd_np_wr = 1; cmd_p_wr = 1; cmd_to_bus = 1;
        words_rd_rsp = 5; words_np_wr = 3; words_p_wr = 15; words_to_bus = 2;
        step();
        chk("R5 rd words only", cnt_value, 32'd30);
    endtask

    task automatic t_discard();
        wr_ctl(32'h0000_1003);
        wr_cnt(32'h0);
        disc_vld = 1; disc_amt = 9;
        step();
        chk("R6 discard 9", cnt_value, 32'd9);
        disc_vld = 1; disc_amt = 0;
        step();
        chk("R6 discard 0", cnt_value, 32'd9);
        disc_amt = 7; cmd_rd_rsp = 1; words_rd_rsp = 4;
        step();
        chk("R13 no strobe / txn cmd", cnt_value, 32'd9);
    endtask

    task automatic t_chain();
        wr_ctl(32'h0000_0803);
        wr_cnt(32'h0);
        chain_first = 1; chain_pkts = 3; cmd_np_wr = 1;
        step();
        chk("R7 chain 3", cnt_value, 32'd3);
        chain_first = 1; chain_pkts = 4;
        step();
        chk("R7 chain 4", cnt_value, 32'd7);
    endtask

    task automatic t_idle();
        wr_ctl(32'h0000_0103);
        wr_cnt(32'h0);
        bus_frame = 0;
        step();
        chk("R8 idle clock", cnt_value, 32'd1);
        step();
        chk("R8 frame busy", cnt_value, 32'd1);
        bus_frame = 0; bus_trdy = 1;
        step();
        chk("R8 trdy busy", cnt_value, 32'd1);
    endtask

    task automatic t_wait_lat();
        wr_ctl(32'h0000_0603);
        wr_cnt(32'h0);
        wait_cyc = 1; rd_lat_cyc = 1;
        step();
        chk("R9 wait+lat", cnt_value, 32'd2);
        wait_cyc = 1;
        step();
        chk("R9 wait only", cnt_value, 32'd3);
    endtask

    task automatic t_simul();
        wr_ctl(32'h0000_1F03);
        wr_cnt(32'h0);
        disc_vld = 1; disc_amt = 15; chain_first = 1; chain_pkts = 4;
        rd_lat_cyc = 1; wait_cyc = 1; bus_frame = 0;
        step();
        chk("R10 all bus events", cnt_value, 32'd22);
    endtask

    task automatic t_sat();
        wr_ctl(32'h0000_1003);
        wr_cnt(32'hFFFF_FFF0);
        disc_vld = 1; disc_amt = 15;
        step();
        chk("R11 reach max", cnt_value, 32'hFFFF_FFFF);
        disc_vld = 1; disc_amt = 15;
        step();
        chk("R11 hold max", cnt_value, 32'hFFFF_FFFF);
    endtask

    task automatic t_wr_prio();
        wr_ctl(32'h0000_1003);
        disc_vld = 1; disc_amt = 15;
        reg_wr_en = 1; reg_wr_sel = 1; reg_wr_data = 32'd100;
        step();
        chk("R12 write wins", cnt_value, 32'd100);
        disc_vld = 1; disc_amt = 5;
        step();
        chk("R12 count after write", cnt_value, 32'd105);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_ctl();
        t_gate();
        t_txn_cmd();
        t_words();
        t_discard();
        t_chain();
        t_idle();
        t_wait_lat();
        t_simul();
        t_sat();
        t_wr_prio();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule